// File: doc/BRIEF.md
# FIR Filter Multiply-Accumulate Engine

This block is a sequential finite-impulse-response filter. Each accepted input sample goes into a small circular sample memory. The engine then spends one clock per tap multiplying a coefficient by a stored sample and adding the product to a wide accumulator. Coefficients live in their own register bank, separate from the sample memory. Both operands of a tap are therefore read in the same cycle, and the multiplier and adder together finish one tap per clock.

Upstream logic offers samples over a valid/ready handshake. Ready drops for the whole computation and comes back in the cycle in which the result appears. The result is presented for a single cycle, rounded and saturated to the sample width. Software or a loader writes coefficients through a simple write port, and the engine accepts such writes only while it is idle.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, out_data is 0, and every stored sample and coefficient is zero.
- R2: A sample is taken on a clock edge where in_valid and in_ready are both 1. in_ready is then 0 for the next TAPS (8) cycles.
- R3: The result for a sample x[n] is acc = sum over k = 0..TAPS-1 of a_k * x[n-k]. The x[n-k] are the TAPS most recently accepted samples, and older history that wraps around the circular memory is reused correctly. The accumulator starts from zero for every result.
- R4: out_valid is 1 for exactly one cycle, in the cycle that follows the TAPS-th clock edge after the accepting edge.
- R5: out_data equals floor((acc + 2^14) / 2^15), which rounds half up from Q15. For example, with a0 = 1 and other coefficients zero, inputs 16384, 16383, -16384 and -16385 give 1, 0, 0 and -1.
- R6: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R7: When the engine is idle and coef_we is 1, coef_data is written as a_k with k = coef_addr. Coefficient a_k multiplies the sample accepted k samples before the newest one.
- R8: A coefficient write issued while the engine is busy (in_ready = 0) is ignored.
- R9: A sample offered while in_ready is 0 is not taken and does not enter the history.
- R10: in_ready is 1 in the same cycle as out_valid, so a new sample can be taken at the next edge. With in_valid held high, a new result appears every TAPS + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine idle and able to take a sample |
| in_data | input | 16 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Coefficient index k |
| coef_data | input | 16 | Signed Q15 coefficient value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Rounded, saturated signed result |

## Verification
The bench builds the engine with its defaults: eight taps, 16-bit samples and coefficients, a 40-bit accumulator and a 15-bit rounding shift. With eight taps, a stream of about forty back-to-back samples wraps the circular write pointer several times, and full-scale operands drive the rounded sum far past both saturation limits. The bench places single non-zero coefficients at chosen indices to confirm which coefficient meets which past sample, and to hit the exact half-LSB rounding boundaries. It also offers samples and coefficient writes while the engine is busy.

// File: rtl/fir_mac_pkg.sv
// Package: shared control encoding for the FIR MAC engine.
// Assumes: nothing beyond SystemVerilog 2017.
package fir_mac_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fir_state_e;
endpackage

// File: rtl/fir_sample_ring.sv
// Module: fir_sample_ring
// Holds the TAPS most recent input samples in a circular register array.
// A push writes at the write pointer, which then wraps modulo TAPS. The read
// port returns the sample that is rd_age pushes older than the newest one.
// Assumes: TAPS >= 2 and rd_age < TAPS.
module fir_sample_ring #(
    parameter int TAPS = 8,
    parameter int DW   = 16,
    localparam int PW  = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic [PW-1:0] rd_age,
    output logic [DW-1:0] rd_data
);
    localparam logic [PW-1:0] LAST_SLOT = PW'(TAPS - 1);

    logic [DW-1:0] slots_q [TAPS];
    logic [PW-1:0] wr_ptr_q;
    logic [PW-1:0] newest_q;
    logic [PW:0]   rd_idx_wide;

    // Store a pushed sample and advance the circular write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) slots_q[i] <= '0;
            wr_ptr_q <= '0;
            newest_q <= LAST_SLOT;
        end else if (push) begin
            slots_q[wr_ptr_q] <= push_data;
            newest_q          <= wr_ptr_q;
            wr_ptr_q          <= (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
        end
    end

    // Map an age to a slot index, wrapping below slot zero.
    always_comb begin
        if ({1'b0, rd_age} <= {1'b0, newest_q})
            rd_idx_wide = {1'b0, newest_q} - {1'b0, rd_age};
        else
            rd_idx_wide = {1'b0, newest_q} + (PW+1)'(TAPS) - {1'b0, rd_age};
    end

    assign rd_data = slots_q[rd_idx_wide[PW-1:0]];
endmodule

// File: rtl/fir_coef_bank.sv
// Module: fir_coef_bank
// A coefficient register bank with one write port and one read port,
// independent of the sample memory so both can be read in the same cycle.
// Assumes: wr_allow is driven low by the controller while a result is pending.
module fir_coef_bank #(
    parameter int TAPS = 8,
    parameter int CW   = 16,
    localparam int PW  = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_allow,
    input  logic [PW-1:0] wr_idx,
    input  logic [CW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [CW-1:0] rd_data
);
    logic [CW-1:0] coef_q [TAPS];

    // Write a coefficient only when the controller permits it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) coef_q[i] <= '0;
        end else if (wr_en && wr_allow) begin
            coef_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = coef_q[rd_idx];
endmodule

// File: rtl/fir_mac_unit.sv
// Module: fir_mac_unit
// A single-cycle multiply-accumulate with rounding and saturation. On each
// enabled cycle it adds sample*coef to the accumulator, or to zero when clr
// is set. On the last tap it registers the rounded, clamped result and
// raises out_valid for one cycle.
// Assumes: FRAC >= 1 and AW >= DW + CW + $clog2(TAPS).
module fir_mac_unit #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int AW   = 40,
    parameter int OW   = 16,
    parameter int FRAC = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          clr,
    input  logic          last,
    input  logic [DW-1:0] sample,
    input  logic [CW-1:0] coef,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);
    localparam int PRW = DW + CW;
    localparam logic signed [AW:0] RND_BIAS = (AW+1)'(64'sd1 <<< (FRAC - 1));
    localparam logic signed [AW:0] SAT_HI   = (AW+1)'((64'sd1 <<< (OW - 1)) - 64'sd1);
    localparam logic signed [AW:0] SAT_LO   = (AW+1)'(-(64'sd1 <<< (OW - 1)));

    logic signed [PRW-1:0] product;
    logic signed [AW-1:0]  acc_q;
    logic signed [AW-1:0]  acc_next;
    logic signed [AW:0]    rounded;
    logic signed [AW:0]    scaled;
    logic [OW-1:0]         clamped;

    // Form the product and the next accumulator value.
    always_comb begin
        product  = $signed(sample) * $signed(coef);
        acc_next = (clr ? '0 : acc_q) + {{(AW-PRW){product[PRW-1]}}, product};
    end

    // Round half up, rescale, then clamp to the output range.
    always_comb begin
        rounded = $signed({acc_next[AW-1], acc_next}) + RND_BIAS;
        scaled  = rounded >>> FRAC;
        if (scaled > SAT_HI)      clamped = SAT_HI[OW-1:0];
        else if (scaled < SAT_LO) clamped = SAT_LO[OW-1:0];
        else                      clamped = scaled[OW-1:0];
    end

    // Hold the running sum and publish the result on the last tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= en && last;
            if (en) acc_q <= acc_next;
            if (en && last) out_data <= clamped;
        end
    end
endmodule

// File: rtl/fir_mac_engine.sv
// Module: fir_mac_engine (top)
// A sequential FIR filter: it accepts one sample, then runs TAPS
// multiply-accumulate cycles over the circular sample history and the
// coefficient bank, and emits one rounded, saturated result.
// Assumes: TAPS >= 2; coefficients are signed Q(FRAC) values.
module fir_mac_engine #(
    parameter int TAPS = 8,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int AW   = 40,
    parameter int FRAC = 15,
    localparam int PW  = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          coef_we,
    input  logic [PW-1:0] coef_addr,
    input  logic [CW-1:0] coef_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    import fir_mac_pkg::*;

    localparam logic [PW-1:0] LAST_TAP = PW'(TAPS - 1);

    fir_state_e    state_q;
    logic [PW-1:0] tap_q;
    logic          accept;
    logic          running;
    logic [DW-1:0] smp_rd;
    logic [CW-1:0] cf_rd;

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign running  = (state_q == ST_RUN);

    // Sequence one MAC per tap after each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tap_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    tap_q <= '0;
                    if (accept) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (tap_q == LAST_TAP) begin
                        state_q <= ST_IDLE;
                        tap_q   <= '0;
                    end else begin
                        tap_q <= tap_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    fir_sample_ring #(.TAPS(TAPS), .DW(DW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_data (in_data),
        .rd_age    (tap_q),
        .rd_data   (smp_rd)
    );

    fir_coef_bank #(.TAPS(TAPS), .CW(CW)) u_coef (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (coef_we),
        .wr_allow (in_ready),
        .wr_idx   (coef_addr),
        .wr_data  (coef_data),
        .rd_idx   (tap_q),
        .rd_data  (cf_rd)
    );

    fir_mac_unit #(.DW(DW), .CW(CW), .AW(AW), .OW(DW), .FRAC(FRAC)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (running),
        .clr       (tap_q == '0),
        .last      (tap_q == LAST_TAP),
        .sample    (smp_rd),
        .coef      (cf_rd),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/fir_mac_engine_chk.sv
// Module: fir_mac_engine_chk
// Port-level timing checker for fir_mac_engine. It keeps its own count of
// cycles since each accepted sample to check busy time and result timing.
// Assumes: attached through the bind below.
module fir_mac_engine_chk #(
    parameter int TAPS = 8,
    localparam int NW  = $clog2(TAPS + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid
);
    logic [NW-1:0] since_q;

    // Count cycles from an accepted sample up to TAPS.
    always_ff @(posedge clk) begin
        if (!rst_n)                              since_q <= '0;
        else if (in_valid && in_ready)           since_q <= NW'(1);
        else if (since_q == NW'(TAPS))           since_q <= '0;
        else if (since_q != '0)                  since_q <= since_q + 1'b1;
    end

    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != '0) |-> !in_ready);

    p_result_on_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == NW'(TAPS)) |=> out_valid);

    p_no_early_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != NW'(TAPS)) |=> !out_valid);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_ready_with_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);
endmodule

bind fir_mac_engine fir_mac_engine_chk #(.TAPS(TAPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid)
);

// File: tb/fir_mac_engine_tb.sv
// Bench: behavioural reference model (queue history, integer sums) compared
// with the engine every clock, plus directed checks on named corner cases.
module fir_mac_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        coef_we = 1'b0;
    logic [2:0]  coef_addr = '0;
    logic [15:0] coef_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int     hist[$];
    int     coef[8];
    int     busy = 0;
    bit     exp_valid = 1'b0;
    int     exp_data = 0;
    int     pending = 0;
    int     last_out = 0;

    always #5 clk = ~clk;

    fir_mac_engine u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_result();
        longint acc = 0;
        longint r;
        for (int i = 0; i < 8; i++) acc += longint'(coef[i]) * longint'(hist[i]);
        r = (acc + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    // One cycle: compare at the falling edge, drive, then advance the model.
    task automatic cyc(input bit v, input int d, input bit we, input int a, input int cd);
        check("R2 in_ready", int'(in_ready), int'(busy == 0));
        check("R4 out_valid", int'(out_valid), int'(exp_valid));
        if (exp_valid) begin
            check("R3 out_data", int'($signed(out_data)), exp_data);
        end
        if (out_valid) last_out = int'($signed(out_data));
        in_valid  = v;
        in_data   = 16'(d);
        coef_we   = we;
        coef_addr = 3'(a);
        coef_data = 16'(cd);
        @(posedge clk);
        exp_valid = 1'b0;
        if (busy == 0) begin
            if (we) coef[a] = int'($signed(16'(cd)));
            if (v) begin
                void'(hist.pop_back());
                hist.push_front(int'($signed(16'(d))));
                pending = model_result();
                busy = 8;
            end
        end else begin
            busy--;
            if (busy == 0) begin
                exp_valid = 1'b1;
                exp_data = pending;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle_until_ready();
        while (busy != 0) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic set_coef(input int a, input int v);
        idle_until_ready();
        cyc(0, 0, 1, a, v);
    endtask

    task automatic clear_coefs();
        for (int i = 0; i < 8; i++) set_coef(i, 0);
    endtask

    task automatic run_sample(input int x);
        idle_until_ready();
        cyc(1, x, 0, 0, 0);
        for (int i = 0; i < 9; i++) cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            hist.push_back(0);
            coef[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports.
        check("R1 in_ready", int'(in_ready), 1);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_data", int'(out_data), 0);
        run_sample(12345);
        check("R1 zero coefs", last_out, 0);

        // R5: rounding at the half-LSB boundaries with a0 = 1.
        set_coef(0, 1);
        run_sample(16384);  check("R5 +half", last_out, 1);
        run_sample(16383);  check("R5 below +half", last_out, 0);
        run_sample(-16384); check("R5 -half", last_out, 0);
        run_sample(-16385); check("R5 below -half", last_out, -1);

        // R7: a3 multiplies the sample three older than the newest.
        clear_coefs();
        set_coef(3, 16384);
        run_sample(1000); run_sample(2000); run_sample(3000); run_sample(4000);
        check("R7 tap index", last_out, 500);

        // R6: saturation at both limits.
        for (int i = 0; i < 8; i++) set_coef(i, 32767);
        for (int i = 0; i < 8; i++) run_sample(32767);
        check("R6 high clamp", last_out, 32767);
        for (int i = 0; i < 8; i++) run_sample(-32768);
        check("R6 low clamp", last_out, -32768);

        // R8: a coefficient write while busy is ignored.
        clear_coefs();
        idle_until_ready();
        cyc(1, 1000, 0, 0, 0);
        cyc(0, 0, 1, 0, 32767);
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0);
        run_sample(1000);
        check("R8 busy write dropped", last_out, 0);

        // R9: a sample offered while busy does not enter the history.
        set_coef(0, 16384);
        set_coef(1, 16384);
        idle_until_ready();
        cyc(1, 100, 0, 0, 0);
        while (busy != 0) cyc(1, 30000, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        run_sample(200);
        check("R9 busy sample dropped", last_out, 150);

        // R3/R10: random coefficients, back-to-back stream wrapping the ring.
        for (int i = 0; i < 8; i++) set_coef(i, int'($signed(16'($urandom))));
        idle_until_ready();
        for (int n = 0; n < 40; n++) begin
            cyc(1, int'($signed(16'($urandom))), 0, 0, 0);
            while (busy != 0) cyc(1, 7777, 0, 0, 0);
        end
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule